// File: doc/BRIEF.md
# Polyphase Upsampling FIR Interpolator

This block raises the sample rate of a signed sample stream by an integer factor. Zero-stuffing followed by low-pass filtering is never done literally. The prototype low-pass filter is split into one subfilter per output phase, and every subfilter works on the same short history of real input samples at the input rate. Each accepted input sample produces one output word that carries one filtered sample per phase. Lane 0 holds the earliest phase of the upsampled sequence.

Coefficients are signed Q1.15 values and are written one at a time through a plain write port, addressed by their index in the prototype filter. Each product sum is formed at full width. It is then rounded once to the sample width and saturated.

Both the sample input and the output word use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The output holds one word. The input is ready only while that word is empty or is being taken in the same cycle, so a stalled output stops the input. A producer may keep `in_valid` high through a stall. The data it presents is not taken until `in_ready` returns.

Top module: `polyphase_interp`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1. Reset clears the sample history to zero, so the first output after reset treats all earlier inputs as 0.
- R2: For input sample n, lane p of `out_data` (bits p*SAMPLE_W upward) equals sat(round(sum over k of h[p+k*PHASES]*x[n-k])), with k from 0 to TAPS-1. Lane p therefore uses subfilter p, the prototype coefficients p, p+PHASES, p+2*PHASES and so on.
- R3: Rounding adds 2^14 to the full-width sum and then shifts it arithmetically right by 15. A sum of +16384 gives 1, a sum of +16383 gives 0, and a sum of -16384 gives 0.
- R4: A rounded result above 32767 is output as 32767. A rounded result below -32768 is output as -32768. This is shown for SAMPLE_W=16.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An input sample enters the history only in a cycle where both `in_valid` and `in_ready` are high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: Each accepted input produces exactly one output word, and `out_valid` is high in the cycle after the acceptance. With no acceptance, `out_valid` falls after a cycle in which `out_ready` is high.
- R8: A write with `coef_we` high at `coef_addr`=i, where i is below PHASES*TAPS, sets h[i] to `coef_data` from the next cycle on. A write at i of PHASES*TAPS or above changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 80 | PHASES signed samples, lane 0 in the low bits |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Prototype coefficient index |
| coef_data | input | 16 | Signed Q1.15 coefficient |

## Verification
An impulse shows each prototype coefficient by itself on its lane and tap position. A wrong phase-to-coefficient mapping or a history off by one therefore shows up directly. A pseudo-random sequence of samples, run against distinct coefficients, exercises the full sum of products and the sign handling. Single-coefficient inputs at exactly ±16384 and one step off show the rounding direction. Full-scale coefficients with full-scale inputs show saturation at both limits. A stall that offers a different sample while the output is held shows that nothing enters the history until ready returns. A write to an index past the last coefficient shows that it leaves every output unchanged.

// File: rtl/polyi_pkg.sv
package polyi_pkg;
  // Coefficient format: signed Q1.15
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
endpackage

// File: rtl/polyi_coef_bank.sv
module polyi_coef_bank
  import polyi_pkg::*;
#(
  parameter int PHASES = 5,
  parameter int TAPS   = 4,
  localparam int NCOEF  = PHASES * TAPS,
  localparam int ADDR_W = $clog2(NCOEF)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_idx,
  input  logic [COEF_W-1:0]       wr_val,
  output logic [NCOEF*COEF_W-1:0] coef_flat
);
  logic [COEF_W-1:0] bank_q [NCOEF];
  logic in_range;

  assign in_range = {1'b0, wr_idx} < (ADDR_W+1)'(NCOEF);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCOEF; i++) bank_q[i] <= '0;
    end else if (wr_en && in_range) begin
      bank_q[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < NCOEF; g++) begin : g_flat
    assign coef_flat[g*COEF_W +: COEF_W] = bank_q[g];
  end

  // R8
  coef_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && in_range |=> coef_flat[$past(wr_idx)*COEF_W +: COEF_W] == $past(wr_val));

  // R8
  coef_oob_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !in_range |=> $stable(coef_flat));
endmodule

// File: rtl/polyi_history.sv
module polyi_history #(
  parameter int SAMPLE_W = 16,
  parameter int TAPS     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift,
  input  logic [SAMPLE_W-1:0]      din,
  output logic [TAPS*SAMPLE_W-1:0] hist_flat
);
  logic [SAMPLE_W-1:0] line_q [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) line_q[k] <= '0;
    end else if (shift) begin
      line_q[0] <= din;
      for (int k = 1; k < TAPS; k++) line_q[k] <= line_q[k-1];
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_flat
    assign hist_flat[g*SAMPLE_W +: SAMPLE_W] = line_q[g];
  end

  // R5
  hist_takes_newest_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> hist_flat[SAMPLE_W-1:0] == $past(din));

  // R5
  hist_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(hist_flat));
endmodule

// File: rtl/polyi_phase.sv
module polyi_phase
  import polyi_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PHASES   = 5,
  parameter int TAPS     = 4,
  parameter int PHASE    = 0,
  localparam int NCOEF  = PHASES * TAPS,
  localparam int PROD_W = SAMPLE_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TAPS) + 1
) (
  input  logic [TAPS*SAMPLE_W-1:0] x_flat,
  input  logic [NCOEF*COEF_W-1:0]  coef_flat,
  output logic [SAMPLE_W-1:0]      y
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] SMAX = (ACC_W'(1) <<< (SAMPLE_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SMIN = -(ACC_W'(1) <<< (SAMPLE_W - 1));

  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0]  acc, rnd, shr;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [SAMPLE_W-1:0] xs;
    logic signed [COEF_W-1:0]   hs;
    assign xs = x_flat[k*SAMPLE_W +: SAMPLE_W];
    assign hs = coef_flat[(PHASE + k*PHASES)*COEF_W +: COEF_W];
    assign prod[k] = xs * hs;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
    rnd = acc + HALF;
    shr = rnd >>> COEF_FRAC;
    if (shr > SMAX)      y = SMAX[SAMPLE_W-1:0];
    else if (shr < SMIN) y = SMIN[SAMPLE_W-1:0];
    else                 y = shr[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp
  import polyi_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PHASES   = 5,
  parameter int TAPS     = 4,
  localparam int NCOEF  = PHASES * TAPS,
  localparam int ADDR_W = $clog2(NCOEF),
  localparam int WORD_W = PHASES * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  input  logic                coef_we,
  input  logic [ADDR_W-1:0]   coef_addr,
  input  logic [COEF_W-1:0]   coef_data
);
  logic                     accept;
  logic [TAPS*SAMPLE_W-1:0] hist_flat, next_hist;
  logic [NCOEF*COEF_W-1:0]  coef_flat;
  logic [WORD_W-1:0]        lanes;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  polyi_coef_bank #(.PHASES(PHASES), .TAPS(TAPS)) u_coef (
    .clk(clk), .rst(rst), .wr_en(coef_we), .wr_idx(coef_addr),
    .wr_val(coef_data), .coef_flat(coef_flat)
  );

  polyi_history #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_hist (
    .clk(clk), .rst(rst), .shift(accept), .din(in_data), .hist_flat(hist_flat)
  );

  // newest sample in tap 0, oldest stored sample drops off (TAPS >= 2)
  assign next_hist = {hist_flat[(TAPS-1)*SAMPLE_W-1:0], in_data};

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    polyi_phase #(.SAMPLE_W(SAMPLE_W), .PHASES(PHASES), .TAPS(TAPS), .PHASE(p)) u_ph (
      .x_flat(next_hist), .coef_flat(coef_flat), .y(lanes[p*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= lanes;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7
  one_word_per_input_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && out_ready |=> !out_valid);
endmodule

// File: tb/polyphase_interp_tb.sv
module polyphase_interp_tb;
  localparam int SW = 16, PH = 5, TP = 4, NC = PH * TP;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1, coef_we = 0;
  logic [SW-1:0] in_data = '0;
  logic [4:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic in_ready, out_valid;
  logic [PH*SW-1:0] out_data;

  int checks = 0, errors = 0;
  int h [NC];
  int xh [TP];
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  polyphase_interp u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
  );

  function automatic int model_lane(int p);
    longint acc = 0;
    longint r;
    for (int k = 0; k < TP; k++) acc += longint'(h[p + k*PH]) * longint'(xh[k]);
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b", req, got, exp);
    end
  endtask

  task automatic check_word(string req);
    check_bit(req, out_valid, 1'b1);
    for (int p = 0; p < PH; p++) begin
      int got, exp;
      got = int'($signed(out_data[p*SW +: SW]));
      exp = model_lane(p);
      checks++;
      if (got != exp) begin
        errors++;
        $display("FAIL %s lane %0d got %0d exp %0d", req, p, got, exp);
      end
    end
  endtask

  task automatic write_coef(int idx, int val);
    @(negedge clk);
    coef_we = 1; coef_addr = 5'(idx); coef_data = 16'(val);
    if (idx < NC) h[idx] = int'($signed(16'(val)));
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic push_model(int x);
    for (int k = TP-1; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = x;
  endtask

  task automatic send(int x, string req);
    @(negedge clk);
    in_valid = 1; in_data = 16'(x); out_ready = 1;
    @(posedge clk);
    push_model(int'($signed(16'(x))));
    @(negedge clk);
    in_valid = 0;
    check_word(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) h[i] = 0;
    for (int k = 0; k < TP; k++) xh[k] = 0;
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid in reset", out_valid, 1'b0);
    rst = 0;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);

    // distinct coefficients; R8 out-of-range writes must change nothing
    for (int i = 0; i < NC; i++) write_coef(i, (i * 2731) % 20000 - 10000);
    write_coef(NC, 16'h7FFF);
    write_coef(31, 16'h8000);

    // R2 impulse: every coefficient appears alone on its lane and tap
    send(32767, "R2 impulse");
    for (int j = 0; j < TP; j++) send(0, "R2 impulse tail");
    // R8 update of a single coefficient is seen on its lane
    write_coef(7, 12345);
    send(-20000, "R8 rewritten coef");
    // R2 pseudo-random sweep
    for (int j = 0; j < 40; j++) begin
      seed = seed * 1103515245 + 12345;
      send(int'($signed(seed[23:8])), "R2 random");
    end

    // R3 rounding with single unit coefficients
    for (int i = 0; i < NC; i++) write_coef(i, 0);
    write_coef(0, 1);
    write_coef(1, -1);
    send(16384, "R3 half up");
    send(16383, "R3 below half");
    send(-16384, "R3 negative half");
    send(-16385, "R3 negative below half");

    // R4 saturation at both rails
    for (int i = 0; i < NC; i++) write_coef(i, 16'h7FFF);
    for (int j = 0; j < TP; j++) send(32767, "R4 positive rail");
    for (int j = 0; j < TP; j++) send(-32768, "R4 negative rail");

    // R5 R6 R9-style stall: offered sample must not enter history
    for (int i = 0; i < NC; i++) write_coef(i, (i * 977) % 8000 - 4000);
    @(negedge clk);
    in_valid = 1; in_data = 16'(1111); out_ready = 0;
    @(posedge clk);
    push_model(1111);
    @(negedge clk);
    in_data = 16'(-2222);
    check_word("R6 stalled word");
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check_bit("R5 in_ready low in stall", in_ready, 1'b0);
      check_word("R6 word held");
    end
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    check_bit("R7 drained", out_valid, 1'b0);
    send(3333, "R5 rejected sample absent");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule